// File: doc/BRIEF.md
# Decimal Adjust Unit for a Two-Byte Accumulator

This block applies one decimal correction step to a 16-bit accumulator, formed of a low byte and a high byte. An arithmetic unit runs it after a binary add, subtract, multiply or before a divide on decimal digits. It takes the carry and half-carry flags that the previous binary operation produced. A 3-bit opcode picks one of six corrections:

- packed-digit add and subtract fixes, where each byte holds two decimal digits;
- unpacked-digit add and subtract fixes, where each byte holds one digit;
- a split of the low byte by a base;
- a fold of the high byte into the low byte by a base.

The block returns the corrected accumulator, carry and half-carry flags, zero, sign and parity flags, and a fault output. The fault output is raised when a split is asked for with a zero base.

The correction logic is purely combinational. A parameter selects either a registered output stage with one clock of latency or a direct combinational path. The default is the registered stage.

Top module: `bcd_adjust_unit`

## Requirements
- R1: Opcode 0 (packed add fix): a low nibble above 9 or a set half-carry input adds 6 to the low byte and sets the half-carry output. An original low byte above 0x99 or a set carry input adds a further 0x60 and sets the carry output. Each output flag whose condition is false is 0.
- R2: Opcode 1 (packed subtract fix): a low nibble above 9 or a set half-carry input sets the half-carry output and subtracts 6. In that same step, the carry output is set if the original low byte was below 6 or the carry input was set. An original low byte above 0x99 or a set carry input subtracts a further 0x60 and sets the carry output.
- R3: For opcodes 0 to 5 without a fault, the three result flags come from the new low byte. The zero flag is 1 when the byte is 0. The sign flag equals bit 7. The parity flag is 1 when the byte has an even number of one bits.
- R4: Opcodes 0 and 1 leave the high byte unchanged.
- R5: Opcode 2 (unpacked add fix): a low nibble above 9 or a set half-carry input makes the low byte ((L+6) mod 16). The high byte increases by 1, plus 1 more when the original low byte exceeded 0xF9, modulo 256. Carry and half-carry outputs are both set.
- R6: Opcode 3 (unpacked subtract fix): under the same condition as R5, the low byte becomes ((L-6) mod 16). The high byte decreases by 1, plus 1 more when the original low byte was below 6, modulo 256. Carry and half-carry outputs are both set.
- R7: On opcodes 2 and 3 when the condition is false, the low byte keeps only its low nibble. The high byte is unchanged, and carry and half-carry outputs are 0.
- R8: Opcode 4 (split) with a nonzero base sets the high byte to L / base and the low byte to L mod base. Carry and half-carry outputs are 0.
- R9: Opcode 4 with base 0 raises the fault output, returns the accumulator unchanged and clears all five flags. No other case raises the fault.
- R10: Opcode 5 (fold) sets the low byte to (H*base + L) mod 256 and the high byte to 0, for any base including 0. Carry and half-carry outputs are 0.
- R11: Opcodes 6 and 7 return the accumulator unchanged, with all five flags and the fault output at 0.
- R12: With the default registered stage, results appear one rising edge after the inputs are presented. While reset is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Correction opcode (0 to 5 used, 6 and 7 reserved) |
| acc_in | input | 16 | Accumulator: bits 15:8 high byte, bits 7:0 low byte |
| base_in | input | BASE_W | Base for the split and fold corrections |
| cf_in | input | 1 | Carry flag from the preceding operation |
| af_in | input | 1 | Half-carry flag from the preceding operation |
| acc_out | output | 16 | Corrected accumulator |
| cf_out | output | 1 | Carry flag result |
| af_out | output | 1 | Half-carry flag result |
| zf_out | output | 1 | Zero flag of the new low byte |
| sf_out | output | 1 | Sign flag of the new low byte |
| pf_out | output | 1 | Even parity flag of the new low byte |
| fault_out | output | 1 | Split requested with a zero base |

## Verification
In the default configuration, every output, including the fault, becomes valid one rising edge after the inputs it answers. The bench changes inputs on a falling edge and compares the outputs on the next falling edge, after exactly one capturing edge. One check changes the inputs and looks before the next rising edge, to show that the previous result is still held. The reset check samples while reset is low, and no check is made during the cycle in which reset is released.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

   localparam int BYTE_W = 8;
   localparam int ACC_W  = 2 * BYTE_W;

   localparam logic [2:0] OP_PK_ADD  = 3'd0;
   localparam logic [2:0] OP_PK_SUB  = 3'd1;
   localparam logic [2:0] OP_UP_ADD  = 3'd2;
   localparam logic [2:0] OP_UP_SUB  = 3'd3;
   localparam logic [2:0] OP_SPLIT   = 3'd4;
   localparam logic [2:0] OP_FOLD    = 3'd5;

   typedef struct packed {
      logic [BYTE_W-1:0] hi;
      logic [BYTE_W-1:0] lo;
      logic              cf;
      logic              af;
      logic              zf;
      logic              sf;
      logic              pf;
      logic              fault;
   } adj_res_t;

   function automatic logic even_par(input logic [BYTE_W-1:0] b);
      return ~(^b);
   endfunction

endpackage

// File: rtl/bcd_packed_fix.sv
module bcd_packed_fix
   import bcd_adj_pkg::*;
(
   input  logic              sub_mode,
   input  logic [BYTE_W-1:0] lo_in,
   input  logic              cf_in,
   input  logic              af_in,
   output logic [BYTE_W-1:0] lo_out,
   output logic              cf_out,
   output logic              af_out
);
   logic nib_fix;
   logic byte_fix;
   logic [BYTE_W-1:0] tmp;

   always_comb begin
      nib_fix  = (lo_in[3:0] > 4'd9) | af_in;
      byte_fix = (lo_in > 8'h99) | cf_in;
      tmp      = lo_in;
      cf_out   = 1'b0;
      af_out   = 1'b0;
      if (sub_mode) begin
         if (nib_fix) begin
            af_out = 1'b1;
            if ((lo_in < 8'd6) || cf_in) cf_out = 1'b1;
            tmp = tmp - 8'd6;
         end
         if (byte_fix) begin
            tmp    = tmp - 8'h60;
            cf_out = 1'b1;
         end
      end else begin
         if (nib_fix) begin
            tmp    = tmp + 8'd6;
            af_out = 1'b1;
         end
         if (byte_fix) begin
            tmp    = tmp + 8'h60;
            cf_out = 1'b1;
         end
      end
      lo_out = tmp;
   end
endmodule

// File: rtl/bcd_unpacked_fix.sv
module bcd_unpacked_fix
   import bcd_adj_pkg::*;
(
   input  logic              sub_mode,
   input  logic [BYTE_W-1:0] lo_in,
   input  logic [BYTE_W-1:0] hi_in,
   input  logic              af_in,
   output logic [BYTE_W-1:0] lo_out,
   output logic [BYTE_W-1:0] hi_out,
   output logic              did_fix
);
   logic [BYTE_W-1:0] lo_adj;
   logic [BYTE_W-1:0] hi_step;

   always_comb begin
      did_fix = (lo_in[3:0] > 4'd9) | af_in;
      if (sub_mode) begin
         lo_adj  = lo_in - 8'd6;
         hi_step = 8'd1 + ((lo_in < 8'd6) ? 8'd1 : 8'd0);
      end else begin
         lo_adj  = lo_in + 8'd6;
         hi_step = 8'd1 + ((lo_in > 8'hF9) ? 8'd1 : 8'd0);
      end
      if (did_fix) begin
         lo_out = {4'b0000, lo_adj[3:0]};
         hi_out = sub_mode ? (hi_in - hi_step) : (hi_in + hi_step);
      end else begin
         lo_out = {4'b0000, lo_in[3:0]};
         hi_out = hi_in;
      end
   end
endmodule

// File: rtl/bcd_base_fix.sv
module bcd_base_fix
   import bcd_adj_pkg::*;
#(
   parameter int BASE_W = 8
) (
   input  logic              fold_mode,
   input  logic [BYTE_W-1:0] lo_in,
   input  logic [BYTE_W-1:0] hi_in,
   input  logic [BASE_W-1:0] base_in,
   output logic [BYTE_W-1:0] lo_out,
   output logic [BYTE_W-1:0] hi_out,
   output logic              zero_base
);
   localparam int PROD_W = BYTE_W + BASE_W + 1;

   logic [BYTE_W-1:0] base_b;
   logic [PROD_W-1:0] fold_sum;

   always_comb begin
      base_b    = BYTE_W'(base_in);
      zero_base = (base_b == '0) & ~fold_mode;
      fold_sum  = PROD_W'(hi_in) * PROD_W'(base_in) + PROD_W'(lo_in);
      if (fold_mode) begin
         lo_out = fold_sum[BYTE_W-1:0];
         hi_out = '0;
      end else if (zero_base) begin
         lo_out = lo_in;
         hi_out = hi_in;
      end else begin
         hi_out = lo_in / base_b;
         lo_out = lo_in % base_b;
      end
   end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
   import bcd_adj_pkg::*;
#(
   parameter int BASE_W  = 8,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_sel,
   input  logic [ACC_W-1:0]  acc_in,
   input  logic [BASE_W-1:0] base_in,
   input  logic              cf_in,
   input  logic              af_in,
   output logic [ACC_W-1:0]  acc_out,
   output logic              cf_out,
   output logic              af_out,
   output logic              zf_out,
   output logic              sf_out,
   output logic              pf_out,
   output logic              fault_out
);
   generate
      if (BASE_W < 1 || BASE_W > BYTE_W) begin : g_bad_base
         $error("BASE_W must lie between 1 and the byte width");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
         $error("OUT_REG must be 0 or 1");
      end
   endgenerate

   logic [BYTE_W-1:0] lo, hi;
   assign lo = acc_in[BYTE_W-1:0];
   assign hi = acc_in[ACC_W-1:BYTE_W];

   logic [BYTE_W-1:0] pk_lo;
   logic              pk_cf, pk_af;
   logic [BYTE_W-1:0] up_lo, up_hi;
   logic              up_fix;
   logic [BYTE_W-1:0] bs_lo, bs_hi;
   logic              bs_zero;

   bcd_packed_fix u_packed (
      .sub_mode (op_sel[0]),
      .lo_in    (lo),
      .cf_in    (cf_in),
      .af_in    (af_in),
      .lo_out   (pk_lo),
      .cf_out   (pk_cf),
      .af_out   (pk_af)
   );

   bcd_unpacked_fix u_unpacked (
      .sub_mode (op_sel[0]),
      .lo_in    (lo),
      .hi_in    (hi),
      .af_in    (af_in),
      .lo_out   (up_lo),
      .hi_out   (up_hi),
      .did_fix  (up_fix)
   );

   bcd_base_fix #(.BASE_W(BASE_W)) u_base (
      .fold_mode (op_sel[0]),
      .lo_in     (lo),
      .hi_in     (hi),
      .base_in   (base_in),
      .lo_out    (bs_lo),
      .hi_out    (bs_hi),
      .zero_base (bs_zero)
   );

   adj_res_t res;

   always_comb begin
      res = '0;
      res.hi = hi;
      res.lo = lo;
      unique case (op_sel)
         OP_PK_ADD, OP_PK_SUB: begin
            res.lo = pk_lo;
            res.cf = pk_cf;
            res.af = pk_af;
         end
         OP_UP_ADD, OP_UP_SUB: begin
            res.lo = up_lo;
            res.hi = up_hi;
            res.cf = up_fix;
            res.af = up_fix;
         end
         OP_SPLIT, OP_FOLD: begin
            res.lo    = bs_lo;
            res.hi    = bs_hi;
            res.fault = bs_zero;
         end
         default: ;
      endcase
      if (op_sel <= OP_FOLD && !res.fault) begin
         res.zf = (res.lo == '0);
         res.sf = res.lo[BYTE_W-1];
         res.pf = even_par(res.lo);
      end
   end

   adj_res_t res_q;

   generate
      if (OUT_REG == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res;
         end
      end else begin : g_comb
         assign res_q = res;
      end
   endgenerate

   assign acc_out   = {res_q.hi, res_q.lo};
   assign cf_out    = res_q.cf;
   assign af_out    = res_q.af;
   assign zf_out    = res_q.zf;
   assign sf_out    = res_q.sf;
   assign pf_out    = res_q.pf;
   assign fault_out = res_q.fault;
endmodule

// File: rtl/bcd_adjust_chk.sv
module bcd_adjust_chk #(
   parameter int BASE_W  = 8,
   parameter int OUT_REG = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        op_sel,
   input logic [15:0]       acc_in,
   input logic [BASE_W-1:0] base_in,
   input logic [15:0]       acc_out,
   input logic              cf_out,
   input logic              af_out,
   input logic              zf_out,
   input logic              sf_out,
   input logic              pf_out,
   input logic              fault_out
);
   generate
      if (OUT_REG == 1) begin : g_chk
         logic primed;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) primed <= 1'b0;
            else        primed <= 1'b1;
         end

         a_r3_sign_matches: assert property (@(posedge clk) disable iff (!rst_n)
            sf_out |-> acc_out[7]);
         a_r3_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
            zf_out |-> (acc_out[7:0] == 8'h00));
         a_r4_packed_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(op_sel) <= 3'd1) |-> (acc_out[15:8] == $past(acc_in[15:8])));
         a_r7_unpacked_nibble: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && ($past(op_sel) == 3'd2 || $past(op_sel) == 3'd3))
            |-> (acc_out[7:4] == 4'h0 && cf_out == af_out));
         a_r9_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
            fault_out |-> (primed && $past(op_sel) == 3'd4 && $past(base_in) == '0
                           && acc_out == $past(acc_in)));
         a_r10_fold_clears_high: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(op_sel) == 3'd5) |-> (acc_out[15:8] == 8'h00 && !cf_out && !af_out));
         a_r11_reserved_passes: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(op_sel) >= 3'd6)
            |-> (acc_out == $past(acc_in) && !cf_out && !af_out && !zf_out && !sf_out && !pf_out));
      end
   endgenerate
endmodule

bind bcd_adjust_unit bcd_adjust_chk #(.BASE_W(BASE_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_sel    (op_sel),
   .acc_in    (acc_in),
   .base_in   (base_in),
   .acc_out   (acc_out),
   .cf_out    (cf_out),
   .af_out    (af_out),
   .zf_out    (zf_out),
   .sf_out    (sf_out),
   .pf_out    (pf_out),
   .fault_out (fault_out)
);

// File: tb/bcd_adjust_unit_test.sv
module bcd_adjust_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [15:0] acc_in = 16'h0000;
   logic [7:0]  base_in = 8'd0;
   logic        cf_in = 1'b0;
   logic        af_in = 1'b0;
   logic [15:0] acc_out;
   logic        cf_out, af_out, zf_out, sf_out, pf_out, fault_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_adjust_unit uut (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in),
      .base_in(base_in), .cf_in(cf_in), .af_in(af_in), .acc_out(acc_out),
      .cf_out(cf_out), .af_out(af_out), .zf_out(zf_out), .sf_out(sf_out),
      .pf_out(pf_out), .fault_out(fault_out)
   );

   // packed vector: {fault, cf, af, zf, sf, pf, acc[15:0]}
   function automatic logic [21:0] model(input int op, input int h, input int l,
                                         input int b, input bit ci, input bit ai);
      int a = l, hh = h;
      bit c = 0, x = 0, f = 0, z = 0, s = 0, p = 0;
      case (op)
         0: begin
            if ((l % 16) > 9 || ai) begin a = a + 6; x = 1; end
            if (l > 153 || ci) begin a = a + 96; c = 1; end
         end
         1: begin
            if ((l % 16) > 9 || ai) begin x = 1; if (l < 6 || ci) c = 1; a = a - 6; end
            if (l > 153 || ci) begin a = a - 96; c = 1; end
         end
         2: if ((l % 16) > 9 || ai) begin
               a = (l + 6) & 15; hh = h + 1 + ((l > 249) ? 1 : 0); c = 1; x = 1;
            end else a = l & 15;
         3: if ((l % 16) > 9 || ai) begin
               a = (l - 6) & 15; hh = h - 1 - ((l < 6) ? 1 : 0); c = 1; x = 1;
            end else a = l & 15;
         4: if (b == 0) f = 1;
            else begin hh = l / b; a = l % b; end
         5: begin a = h * b + l; hh = 0; end
         default: ;
      endcase
      a = a & 255;
      hh = hh & 255;
      if (op <= 5 && !f) begin
         z = (a == 0);
         s = (a >= 128);
         p = 1;
         for (int k = 0; k < 8; k++) if (((a >> k) & 1) == 1) p = ~p;
      end
      return {f, c, x, z, s, p, 8'(hh), 8'(a)};
   endfunction

   function automatic logic [21:0] observed();
      return {fault_out, cf_out, af_out, zf_out, sf_out, pf_out, acc_out};
   endfunction

   task automatic compare(input logic [21:0] exp_v, input string req);
      checks++;
      if (observed() !== exp_v) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (op=%0d acc_in=%h base=%0d cf=%0b af=%0b)",
                  req, observed(), exp_v, op_sel, acc_in, base_in, cf_in, af_in);
      end
   endtask

   task automatic apply(input int op, input int h, input int l, input int b,
                        input bit ci, input bit ai, input string req);
      @(negedge clk);
      op_sel = 3'(op); acc_in = {8'(h), 8'(l)}; base_in = 8'(b);
      cf_in = ci; af_in = ai;
      @(posedge clk);
      @(negedge clk);
      compare(model(op, h, l, b, ci, ai), req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [21:0] held;
      op_sel = 3'd2; acc_in = 16'h12FF; cf_in = 1'b1; af_in = 1'b1;
      repeat (3) @(negedge clk);
      compare(22'h0, "R12 reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 and R2 packed sweeps, with R3 and R4 on every vector
      for (int l = 0; l < 256; l++)
         for (int f = 0; f < 4; f++) begin
            apply(0, 8'hA5, l, 0, f[0], f[1], "R1 R3 R4");
            apply(1, 8'h3C, l, 0, f[0], f[1], "R2 R3 R4");
         end

      // R5 R6 R7 unpacked sweeps, high byte at wrap points
      for (int l = 0; l < 256; l++)
         for (int f = 0; f < 4; f++) begin
            apply(2, 8'h00, l, 0, f[0], f[1], "R5 R7");
            apply(2, 8'hFF, l, 0, f[0], f[1], "R5 R7");
            apply(3, 8'h00, l, 0, f[0], f[1], "R6 R7");
            apply(3, 8'h01, l, 0, f[0], f[1], "R6 R7");
         end

      // R8 split over many bases, R9 zero base
      for (int l = 0; l < 256; l++) begin
         apply(4, 8'h77, l, 0, 1'b1, 1'b1, "R9");
         for (int b = 1; b <= 16; b++) apply(4, 8'h77, l, b, 1'b0, 1'b0, "R8");
         apply(4, 8'h10, l, 255, 1'b1, 1'b0, "R8");
      end

      // R10 fold over high bytes and bases, including base 0
      for (int h = 0; h < 256; h++)
         for (int bi = 0; bi < 4; bi++) begin
            apply(5, h, 8'h09, (bi == 0) ? 0 : (bi == 1) ? 10 : (bi == 2) ? 16 : 255,
                  1'b1, 1'b1, "R10");
            apply(5, h, 8'hFF, (bi == 0) ? 0 : (bi == 1) ? 10 : (bi == 2) ? 16 : 255,
                  1'b0, 1'b0, "R10");
         end

      // R11 reserved codes
      for (int l = 0; l < 256; l++) begin
         apply(6, 255 - l, l, 0, 1'b1, 1'b1, "R11");
         apply(7, l, 255 - l, 3, 1'b0, 1'b1, "R11");
      end

      // R12 latency: new inputs do not show before the next rising edge
      apply(0, 8'h12, 8'h9A, 0, 1'b0, 1'b0, "R12 R1");
      held = model(0, 8'h12, 8'h9A, 0, 1'b0, 1'b0);
      @(negedge clk);
      op_sel = 3'd5; acc_in = 16'h0304; base_in = 8'd10;
      #1;
      compare(held, "R12 hold");
      @(posedge clk);
      @(negedge clk);
      compare(model(5, 3, 4, 10, 1'b0, 1'b0), "R12 R10");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule